// File: doc/BRIEF.md
# Time-Sliced Parallel Crossbar Fabric

This block is a switch fabric made of several identical N x N crossbar planes that share the work by time-slicing. Each plane carries every cell it is given in full. A plane needs several cell times to move one cell, so the fabric hands each new cell time to the next plane in a fixed round-robin order. In every cell time, which is one clock cycle here, the selected plane takes the current match together with the cells offered at the inputs. It keeps that configuration while the transfer runs. When its turn comes round again, it delivers those cells to the output ports and loads the next match.

Each input port presents one cell per cycle, with a valid flag and the index of the output it wants. A small built-in arbiter stands in for the scheduler and turns these requests into a partial permutation. Output ports present the delivered cells, one per port per cycle, with a valid flag. A plane-pointer port exposes which plane takes the current cell time. A flag reports cell times in which two inputs asked for the same output.

Top module: `tslice_xbar`

## Requirements
- R1: Reset is synchronous and active high. While reset is held, and in the first cycle after it is released, outValid is all zero, planeSel is 0 and conflictErr is 0.
- R2: planeSel advances by one on every clock edge outside reset and wraps from NUM_PLANES-1 to 0.
- R3: Take a valid cell on input i whose request field inDest[i*DEST_W +: DEST_W] holds o, and which wins its output. After exactly NUM_PLANES clock edges, this cell appears unchanged on outCell[o*CELL_W +: CELL_W] with outValid[o] high. Before NUM_PLANES edges have passed after reset, no output is valid.
- R4: A plane's match and stored cells stay fixed for the NUM_PLANES cell times that follow its load. New input values in those cycles do not alter cells already in flight.
- R5: When several valid inputs request the same output in one cell time, the lowest-numbered input wins and the others are dropped. conflictErr is high in the cycle after that cell time, and only then.
- R6: An output with no valid requester in a cell time shows outValid low and outCell zero NUM_PLANES edges later.
- R7: Cells between any one input and any one output leave in the order in which they entered.
- R8: An input whose valid bit is low is ignored. Its cell is not delivered and its request field takes no part in the conflict check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cell time per cycle |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | NUM_PORTS | Per-input cell valid |
| inDest | input | NUM_PORTS*DEST_W | Per-input requested output index, input i at bits [i*DEST_W +: DEST_W] |
| inCell | input | NUM_PORTS*CELL_W | Per-input cell, input i at bits [i*CELL_W +: CELL_W] |
| outValid | output | NUM_PORTS | Per-output delivered-cell valid |
| outCell | output | NUM_PORTS*CELL_W | Per-output delivered cell, output o at bits [o*CELL_W +: CELL_W] |
| planeSel | output | PLANE_W | Plane that takes the current cell time |
| conflictErr | output | 1 | High for one cycle after a cell time with an output contention |

## Verification
The assertions assume that the request inputs are stable around each sampling edge. They also assume that reset is held for at least one edge. When NUM_PORTS is not a power of two, request values of NUM_PORTS or above are taken to match no output. The bench drives every input half a cycle away from the rising edge. Its default configuration has four ports, so every request value names a real output. One phase sweeps all 256 combinations of the four request fields with every input valid, which covers each contention pattern the conflict checks can see. Other phases mix valid and invalid inputs whose request fields collide.

// File: rtl/tslice_pkg.sv
`timescale 1ns/1ps
package tslice_pkg;
  // Width of the plane index carried from control to datapath; limits planes to 16.
  localparam int PLANE_IDX_W = 4;

  typedef struct packed {
    logic                   loadEn;    // selected plane loads, and drains its old transfer
    logic [PLANE_IDX_W-1:0] planeIdx;  // plane owning this cell time
  } fabStrobe_t;
endpackage

// File: rtl/tslice_ctrl.sv
`timescale 1ns/1ps
module tslice_ctrl
  import tslice_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_PLANES = 4,
  localparam int DEST_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int PLANE_W = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_PORTS-1:0]  reqValid,
  input  logic [DEST_W-1:0]     reqDest [NUM_PORTS],
  output fabStrobe_t            strobe,
  output logic [NUM_PORTS-1:0]  matchVld,
  output logic [DEST_W-1:0]     matchSrc [NUM_PORTS],
  output logic [PLANE_W-1:0]    planeSel,
  output logic                  conflictErr
);

  logic [PLANE_W-1:0]   ptr;
  logic [NUM_PORTS-1:0] hits [NUM_PORTS];  // hits[o][i]: input i asks for output o
  logic                 anyDup;

  // Round-robin plane pointer, one step per cell time.
  always_ff @(posedge clk) begin
    if (rst)                                   ptr <= '0;
    else if (ptr == PLANE_W'(NUM_PLANES - 1))  ptr <= '0;
    else                                       ptr <= ptr + 1'b1;
  end

  // Request matrix.
  always_comb begin
    for (int o = 0; o < NUM_PORTS; o++)
      for (int i = 0; i < NUM_PORTS; i++)
        hits[o][i] = reqValid[i] && (reqDest[i] == DEST_W'(o));
  end

  // Fixed-priority grant per output: lowest input index wins.
  always_comb begin
    for (int o = 0; o < NUM_PORTS; o++) begin
      matchVld[o] = |hits[o];
      matchSrc[o] = '0;
      for (int i = NUM_PORTS - 1; i >= 0; i--)
        if (hits[o][i]) matchSrc[o] = DEST_W'(i);
    end
  end

  always_comb begin
    anyDup = 1'b0;
    for (int o = 0; o < NUM_PORTS; o++)
      if ($countones(hits[o]) > 1) anyDup = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) conflictErr <= 1'b0;
    else     conflictErr <= anyDup;
  end

  assign strobe.loadEn   = !rst;
  assign strobe.planeIdx = PLANE_IDX_W'(ptr);
  assign planeSel        = ptr;

endmodule

// File: rtl/tslice_planes.sv
`timescale 1ns/1ps
module tslice_planes
  import tslice_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_PLANES = 4,
  parameter int CELL_W     = 16,
  localparam int DEST_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  fabStrobe_t            strobe,
  input  logic [NUM_PORTS-1:0]  matchVld,
  input  logic [DEST_W-1:0]     matchSrc [NUM_PORTS],
  input  logic [CELL_W-1:0]     cellIn   [NUM_PORTS],
  output logic [NUM_PORTS-1:0]  outValid,
  output logic [CELL_W-1:0]     outCell  [NUM_PORTS]
);

  // Per-plane state: cells per input, crossbar setting per output.
  logic [CELL_W-1:0]    cellMem [NUM_PLANES][NUM_PORTS];
  logic [DEST_W-1:0]    cfgSrc  [NUM_PLANES][NUM_PORTS];
  logic [NUM_PORTS-1:0] cfgVld  [NUM_PLANES];

  logic [NUM_PORTS-1:0] drainVld;
  logic [CELL_W-1:0]    drainCell [NUM_PORTS];

  // Only the selected plane is written; all others hold their transfer.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PLANES; p++) begin
      if (rst) begin
        cfgVld[p] <= '0;
      end else if (strobe.loadEn && strobe.planeIdx == PLANE_IDX_W'(p)) begin
        cfgVld[p] <= matchVld;
        for (int k = 0; k < NUM_PORTS; k++) begin
          cfgSrc[p][k]  <= matchSrc[k];
          cellMem[p][k] <= cellIn[k];
        end
      end
    end
  end

  // Crossbar of the plane whose transfer ends in this cell time.
  always_comb begin
    drainVld = '0;
    for (int o = 0; o < NUM_PORTS; o++) drainCell[o] = '0;
    for (int p = 0; p < NUM_PLANES; p++) begin
      if (strobe.planeIdx == PLANE_IDX_W'(p)) begin
        drainVld = cfgVld[p];
        for (int o = 0; o < NUM_PORTS; o++)
          drainCell[o] = cellMem[p][cfgSrc[p][o]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= '0;
      for (int o = 0; o < NUM_PORTS; o++) outCell[o] <= '0;
    end else if (strobe.loadEn) begin
      outValid <= drainVld;
      for (int o = 0; o < NUM_PORTS; o++)
        outCell[o] <= drainVld[o] ? drainCell[o] : '0;
    end
  end

endmodule

// File: rtl/tslice_xbar.sv
`timescale 1ns/1ps
module tslice_xbar
  import tslice_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_PLANES = 4,
  parameter int CELL_W     = 16,
  localparam int DEST_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int PLANE_W = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_PORTS-1:0]          inValid,
  input  logic [NUM_PORTS*DEST_W-1:0]   inDest,
  input  logic [NUM_PORTS*CELL_W-1:0]   inCell,
  output logic [NUM_PORTS-1:0]          outValid,
  output logic [NUM_PORTS*CELL_W-1:0]   outCell,
  output logic [PLANE_W-1:0]            planeSel,
  output logic                          conflictErr
);

  fabStrobe_t          ctrlStrobe;
  logic [NUM_PORTS-1:0] matchVld;
  logic [DEST_W-1:0]   matchSrc [NUM_PORTS];
  logic [DEST_W-1:0]   destArr  [NUM_PORTS];
  logic [CELL_W-1:0]   cellArr  [NUM_PORTS];
  logic [CELL_W-1:0]   outArr   [NUM_PORTS];

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_lane
    assign destArr[g]                   = inDest[g*DEST_W +: DEST_W];
    assign cellArr[g]                   = inCell[g*CELL_W +: CELL_W];
    assign outCell[g*CELL_W +: CELL_W]  = outArr[g];
  end

  tslice_ctrl #(.NUM_PORTS(NUM_PORTS), .NUM_PLANES(NUM_PLANES)) ctrl_i (
    .clk(clk), .rst(rst),
    .reqValid(inValid), .reqDest(destArr),
    .strobe(ctrlStrobe), .matchVld(matchVld), .matchSrc(matchSrc),
    .planeSel(planeSel), .conflictErr(conflictErr)
  );

  tslice_planes #(.NUM_PORTS(NUM_PORTS), .NUM_PLANES(NUM_PLANES), .CELL_W(CELL_W)) planes_i (
    .clk(clk), .rst(rst),
    .strobe(ctrlStrobe), .matchVld(matchVld), .matchSrc(matchSrc),
    .cellIn(cellArr), .outValid(outValid), .outCell(outArr)
  );

endmodule

// File: rtl/tslice_xbar_chk.sv
`timescale 1ns/1ps
module tslice_xbar_chk #(
  parameter int NUM_PORTS  = 4,
  parameter int NUM_PLANES = 4,
  localparam int DEST_W  = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int PLANE_W = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1,
  localparam int CNT_W   = $clog2(NUM_PLANES + 2) + 1
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NUM_PORTS-1:0]        inValid,
  input logic [NUM_PORTS*DEST_W-1:0] inDest,
  input logic [NUM_PORTS-1:0]        outValid,
  input logic [PLANE_W-1:0]          planeSel,
  input logic                        conflictErr
);

  logic             dupNow;
  logic [CNT_W-1:0] sinceRst;

  always_comb begin
    dupNow = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++)
      for (int j = i + 1; j < NUM_PORTS; j++)
        if (inValid[i] && inValid[j] &&
            int'(inDest[i*DEST_W +: DEST_W]) < NUM_PORTS &&
            inDest[i*DEST_W +: DEST_W] == inDest[j*DEST_W +: DEST_W])
          dupNow = 1'b1;
  end

  // Saturating count of active edges since reset.
  always_ff @(posedge clk) begin
    if (rst)                                sinceRst <= '0;
    else if (sinceRst <= CNT_W'(NUM_PLANES)) sinceRst <= sinceRst + 1'b1;
  end

  // R2
  plane_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    planeSel == PLANE_W'(NUM_PLANES - 1) |=> planeSel == '0);

  // R2
  plane_step_chk: assert property (@(posedge clk) disable iff (rst)
    planeSel != PLANE_W'(NUM_PLANES - 1) |=> planeSel == $past(planeSel) + PLANE_W'(1));

  // R3
  quiet_start_chk: assert property (@(posedge clk) disable iff (rst)
    sinceRst <= CNT_W'(NUM_PLANES) |-> outValid == '0);

  // R5
  dup_flag_chk: assert property (@(posedge clk) disable iff (rst)
    dupNow |=> conflictErr);

  // R5
  no_dup_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !dupNow |=> !conflictErr);

endmodule

bind tslice_xbar tslice_xbar_chk #(.NUM_PORTS(NUM_PORTS), .NUM_PLANES(NUM_PLANES)) chk_i (
  .clk(clk), .rst(rst), .inValid(inValid), .inDest(inDest),
  .outValid(outValid), .planeSel(planeSel), .conflictErr(conflictErr)
);

// File: tb/tslice_xbar_tb_top.sv
`timescale 1ns/1ps
module tslice_xbar_tb_top;
  localparam int N   = 4;
  localparam int K   = 4;
  localparam int CW  = 16;
  localparam int DW  = 2;
  localparam int PW  = 2;
  localparam int T_STIM = 370;
  localparam int T_ALL  = T_STIM + K + 2;
  localparam int BUF    = 64;

  logic            clk = 1'b0;
  logic            rst;
  logic [N-1:0]    inValid;
  logic [N*DW-1:0] inDest;
  logic [N*CW-1:0] inCell;
  logic [N-1:0]    outValid;
  logic [N*CW-1:0] outCell;
  logic [PW-1:0]   planeSel;
  logic            conflictErr;

  int  nRun  = 0;
  int  nFail = 0;
  bit  done  = 0;

  logic [N-1:0]  expV [BUF];
  logic [CW-1:0] expD [BUF][N];
  logic          expE [BUF];

  always #5 clk = ~clk;

  tslice_xbar #(.NUM_PORTS(N), .NUM_PLANES(K), .CELL_W(CW)) dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inDest(inDest), .inCell(inCell),
    .outValid(outValid), .outCell(outCell), .planeSel(planeSel), .conflictErr(conflictErr)
  );

  // Stimulus phases: 0..39 rotating permutations, 40..79 mixed with contention,
  // 80..99 invalid inputs with colliding requests, 100..355 sweep of all
  // request combinations, then idle.
  function automatic bit genValid(int t, int i);
    if (t < 40)      return 1'b1;
    if (t < 80)      return (((t >> i) & 1) == 1) || (i == 0);
    if (t < 100)     return 1'b0;
    if (t < 356)     return 1'b1;
    return 1'b0;
  endfunction

  function automatic int genDest(int t, int i);
    if (t < 40)  return (i + t) % N;
    if (t < 80)  return (t * 3 + i * i) % N;
    if (t < 100) return i % 2;
    if (t < 356) return ((t - 100) >> (DW * i)) % N;
    return 0;
  endfunction

  function automatic logic [CW-1:0] genCell(int t, int i);
    return CW'(t * 16 + i) ^ 16'h5a00;
  endfunction

  function automatic string tagOf(int s);
    if (s < 40)  return "R3 R4 R7";
    if (s < 80)  return "R5";
    if (s < 100) return "R8";
    if (s < 356) return "R5";
    return "R6";
  endfunction

  task automatic check(bit ok, string tag, string what, longint got, longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic record(int t);
    logic [N-1:0] v;
    int cnt;
    bit dup;
    dup = 1'b0;
    v   = '0;
    for (int o = 0; o < N; o++) begin
      cnt = 0;
      expD[t % BUF][o] = '0;
      for (int i = N - 1; i >= 0; i--) begin
        if (genValid(t, i) && genDest(t, i) == o) begin
          cnt++;
          v[o] = 1'b1;
          expD[t % BUF][o] = genCell(t, i);
        end
      end
      if (cnt > 1) dup = 1'b1;
    end
    expV[t % BUF] = v;
    expE[t % BUF] = dup;
  endtask

  task automatic drive(int t);
    for (int i = 0; i < N; i++) begin
      inValid[i]            = genValid(t, i);
      inDest[i*DW +: DW]    = DW'(genDest(t, i));
      inCell[i*CW +: CW]    = genCell(t, i);
    end
  endtask

  initial begin
    rst     = 1'b1;
    inValid = '0;
    inDest  = '0;
    inCell  = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state while reset held
    check(outValid == '0, "R1", "outValid in reset", outValid, 0);
    check(planeSel == '0, "R1", "planeSel in reset", planeSel, 0);
    check(conflictErr == 1'b0, "R1", "conflictErr in reset", conflictErr, 0);
    rst = 1'b0;
    for (int t = 0; t < T_ALL; t++) begin
      if (t > 0) begin
        int s;
        s = t - 1;
        // R2: pointer after t active edges
        check(planeSel == PW'(t % K), "R2", $sformatf("planeSel cycle %0d", t), planeSel, t % K);
        check(conflictErr == expE[s % BUF], (s >= 80 && s < 100) ? "R8" : "R5",
              $sformatf("conflictErr for cell time %0d", s), conflictErr, expE[s % BUF]);
        for (int o = 0; o < N; o++) begin
          logic          ev;
          logic [CW-1:0] ed;
          string         tg;
          if (s >= K) begin
            ev = expV[(s - K) % BUF][o];
            ed = expD[(s - K) % BUF][o];
            tg = ev ? tagOf(s - K) : "R6";
          end else begin
            ev = 1'b0;
            ed = '0;
            tg = "R1 R3";
          end
          check({outValid[o], outCell[o*CW +: CW]} == {ev, ed}, tg,
                $sformatf("out%0d cycle %0d {valid,cell}", o, t),
                {outValid[o], outCell[o*CW +: CW]}, {ev, ed});
        end
      end
      if (t < T_STIM) drive(t);
      else begin
        inValid = '0;
        inDest  = '1;
      end
      if (t < T_STIM) record(t);
      else begin
        expV[t % BUF] = '0;
        expE[t % BUF] = 1'b0;
        for (int o = 0; o < N; o++) expD[t % BUF][o] = '0;
      end
      @(posedge clk);
      @(negedge clk);
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule